// File: doc/BRIEF.md
# Two-Pattern Serial Bit Recognizer

This block watches a one-bit serial stream, sampling one bit per clock, and flags every place where the last four sampled bits read either 1101 or 1110. The first bit in each pattern is the oldest bit. Both patterns share a single state graph. Each state stands for the longest tail of the stream that is still the start of one of the two patterns. The patterns begin with the same two bits, so seven states cover them.

The flag is a Moore output and is decoded from the state register alone. It rises in the clock cycle after the edge that samples the final bit of a pattern. Changes on the serial input between edges never reach it. Matches may overlap. Once a pattern completes, the machine keeps any tail of the stream that can still start a new pattern, so one stream can report several patterns that share bits. The block is intended for small framing or marker detectors inside a larger serial datapath.

Top module: `seq_rec`

## Requirements
- R1: While rst_ni is low the machine holds the empty-history state and match_o is 0. After release, no match is reported until four new bits have been sampled.
- R2: After each rising clock edge, match_o is 1 exactly when the last four bits sampled since reset, oldest first, are 1101 or 1110. Otherwise it is 0.
- R3: Overlapping occurrences are all reported. The stream 1101101 raises match_o after its 4th and its 7th bits.
- R4: A run of ones keeps the machine waiting for a 0. The stream 11110 raises match_o only after its 5th bit.
- R5: A pattern may end inside the previous one. The stream 11101 raises match_o after its 4th bit and again after its 5th bit, in two consecutive cycles.
- R6: match_o depends only on the state register. Changing x_i between clock edges does not change match_o.
- R7: The state codes are: empty 000, "1" 001, "11" 010, "110" 011, "1101" 100, "111" 101, "1110" 110. The unused code 111 drives match_o low and returns to 000 on the next edge.
- R8: A reset applied partway through a pattern discards the partial history. After 110, reset, then 1, no match is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the serial bit is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial data bit |
| match_o | output | 1 | High for the cycle after a 1101 or 1110 ends |

## Verification
The bench targets three kinds of corner case.

- **Overlap.** It drives the overlapping streams 1101101 and 11101. A machine that jumps back to the empty state after a match would miss the second occurrence in each.
- **Long runs of ones.** It drives 11110. A machine that leaves the "111" state on another 1 would report late or not at all.
- **Moore property and reset.** It toggles x_i in the middle of a match cycle, which exposes any Mealy-style leak from input to output. It also resets in the middle of a pattern, which catches history that outlives the reset.

A long pseudo-random stream is checked against a four-bit shift-register reference model. Any wrong transition shows up there as a missed or spurious flag.

// File: rtl/seq_rec_pkg.sv
package seq_rec_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_NONE  = 3'b000,
    ST_1     = 3'b001,
    ST_11    = 3'b010,
    ST_110   = 3'b011,
    ST_HIT_A = 3'b100,  // 1101 seen
    ST_111   = 3'b101,
    ST_HIT_B = 3'b110,  // 1110 seen
    ST_SPARE = 3'b111
  } rec_state_e;
endpackage

// File: rtl/seq_rec_next.sv
module seq_rec_next
  import seq_rec_pkg::*;
(
  input  rec_state_e cur_i,
  input  logic       x_i,
  output rec_state_e nxt_o
);
  // next = longest stream suffix that is a prefix of either pattern
  always_comb begin
    unique case (cur_i)
      ST_NONE:  nxt_o = x_i ? ST_1     : ST_NONE;
      ST_1:     nxt_o = x_i ? ST_11    : ST_NONE;
      ST_11:    nxt_o = x_i ? ST_111   : ST_110;
      ST_110:   nxt_o = x_i ? ST_HIT_A : ST_NONE;
      ST_HIT_A: nxt_o = x_i ? ST_11    : ST_NONE;
      ST_111:   nxt_o = x_i ? ST_111   : ST_HIT_B;
      ST_HIT_B: nxt_o = x_i ? ST_HIT_A : ST_NONE;
      default:  nxt_o = ST_NONE;
    endcase
  end
endmodule

// File: rtl/seq_rec_reg.sv
module seq_rec_reg
  import seq_rec_pkg::*;
#(
  parameter rec_state_e RST_VAL = ST_NONE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  rec_state_e d_i,
  output rec_state_e q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/seq_rec_out.sv
module seq_rec_out
  import seq_rec_pkg::*;
(
  input  rec_state_e cur_i,
  output logic       match_o
);
  always_comb match_o = (cur_i == ST_HIT_A) || (cur_i == ST_HIT_B);
endmodule

// File: rtl/seq_rec.sv
module seq_rec
  import seq_rec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic match_o
);
  rec_state_e state_q;
  rec_state_e state_d;

  seq_rec_next u_next (
    .cur_i (state_q),
    .x_i   (x_i),
    .nxt_o (state_d)
  );

  seq_rec_reg #(.RST_VAL(ST_NONE)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  seq_rec_out u_out (
    .cur_i   (state_q),
    .match_o (match_o)
  );
endmodule

// File: rtl/seq_rec_chk.sv
module seq_rec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       x_i,
  input logic       match_o,
  input logic [2:0] state_q
);
  // R2
  match_in_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (state_q == 3'b100 || state_q == 3'b110));

  // R2
  hit_a_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 3'b011 && x_i) |=> (state_q == 3'b100 && match_o));

  // R3
  overlap_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 3'b100 && x_i) |=> (state_q == 3'b010 && !match_o));

  // R4
  ones_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 3'b101 && x_i) |=> (state_q == 3'b101 && !match_o));

  // R5
  chain_b_to_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 3'b110 && x_i) |=> (state_q == 3'b100 && match_o));

  // R7
  spare_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 3'b111) |=> (state_q == 3'b000));
endmodule

bind seq_rec seq_rec_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .x_i     (x_i),
  .match_o (match_o),
  .state_q (state_q)
);

// File: tb/seq_rec_test.sv
module seq_rec_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic match;
  logic [3:0] hist = 4'b0000;
  int total = 0;
  int bad = 0;
  int hits = 0;

  always #(PERIOD/2) clk = ~clk;

  seq_rec uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .x_i     (x),
    .match_o (match)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: match=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive one bit, clock it, compare against the shift-register model
  task automatic step(input logic b, input string tag);
    logic exp;
    x = b;
    @(posedge clk);
    hist = {hist[2:0], b};
    @(negedge clk);
    exp = (hist == 4'b1101) || (hist == 4'b1110);
    check(match, exp, tag);
    if (match) hits++;
  endtask

  task automatic feed(input string bits, input string tag);
    for (int i = 0; i < bits.len(); i++) step(bits[i] == "1", tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    x = 1'b1;
    #(PERIOD*2);
    check(match, 1'b0, tag);
    hist = 4'b0000;
    @(negedge clk);
    rst_n = 1'b1;
    check(match, 1'b0, tag);
  endtask

  task automatic t_reset;
    do_reset("R1 reset");
    feed("111", "R1 post-reset");
    check(match, 1'b0, "R1 no early match");
  endtask

  task automatic t_overlap_a;
    do_reset("R3 reset");
    hits = 0;
    feed("1101101", "R3 overlap");
    check(hits == 2, 1'b1, "R3 two hits");
  endtask

  task automatic t_ones_run;
    do_reset("R4 reset");
    hits = 0;
    feed("1111", "R4 ones");
    check(match, 1'b0, "R4 no match on ones");
    feed("0", "R4 tail");
    check(match, 1'b1, "R4 match after 0");
    check(hits == 1, 1'b1, "R4 one hit");
  endtask

  task automatic t_chain;
    do_reset("R5 reset");
    hits = 0;
    feed("1110", "R5 first");
    check(match, 1'b1, "R5 1110 hit");
    feed("1", "R5 second");
    check(match, 1'b1, "R5 1101 hit");
    check(hits == 2, 1'b1, "R5 two hits");
    feed("00", "R5 drain");
  endtask

  task automatic t_moore;
    do_reset("R6 reset");
    feed("1101", "R6 setup");
    x = 1'b0;
    #(PERIOD/4);
    check(match, 1'b1, "R6 x low mid-cycle");
    x = 1'b1;
    #(PERIOD/8);
    check(match, 1'b1, "R6 x high mid-cycle");
    @(negedge clk);
    hist = {hist[2:0], 1'b1};
    check(match, 1'b0, "R6 after edge");
  endtask

  task automatic t_misses;
    do_reset("R2 reset");
    feed("1100101001111100100", "R2 mixed");
    feed("0000", "R7 idle zeros");
    check(match, 1'b0, "R7 empty code low");
  endtask

  task automatic t_mid_reset;
    do_reset("R8 reset");
    feed("110", "R8 partial");
    do_reset("R8 reset mid");
    feed("1", "R8 after reset");
    check(match, 1'b0, "R8 no stale match");
  endtask

  task automatic t_random;
    logic [15:0] lfsr = 16'hACE1;
    do_reset("R2 random reset");
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], "R2 random");
    end
  endtask

  initial begin
    #(PERIOD*200000);
    bad++;
    $display("FAIL watchdog: finished=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_overlap_a();
    t_ones_run();
    t_chain();
    t_moore();
    t_misses();
    t_mid_reset();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule